// File: doc/BRIEF.md
# Block-Buffered Pseudo-DMA Engine

This engine moves data between a polled host register port and a byte stream on the SCSI side. It never transfers single bytes on demand. Data always moves in whole 128-byte blocks through one internal buffer. The host first selects a direction in the control/status register. It then loads the number of blocks into the block count register, which starts the transfer. While the transfer runs, the host polls the status register until the buffer is ready for it. It then moves the whole block through the data port, either as 128 byte accesses or as 64 word accesses, depending on the `wide_bus` strap.

The other side of the buffer is filled from, or drained to, the SCSI stream. That stream uses a valid/ready handshake. An interrupt input from the SCSI core aborts the transfer while it is running. When the transfer completes, the engine reports that the core registers are available and that the transfer has ended. For host-to-SCSI transfers, it also reports once the final byte has been taken by the stream.

Top module: `pdma_engine`

## Requirements
- R1: After reset the engine is idle: the status register (offset 9) reads 0x0A (bit1 buffer-not-ready = 1, bit3 core-available = 1, every other bit 0), the block count (offset 10) reads 0, and `sin_ready` and `sout_valid` are low.
- R2: A write of a nonzero value N to offset 10 while idle starts a transfer of N blocks and clears status bits 2, 4 and 5. A write of 0 starts nothing. A write to offset 10 during a transfer is ignored. Offset 10 reads the number of blocks not yet finished, and reads 0 at completion.
- R3: When status bit0 (direction) is 1, the buffer takes 128 bytes from the input stream. Bit1 then falls to 0, and reads of the data port (offset 8) return those bytes in arrival order.
- R4: With `wide_bus` = 0 a block is 128 data-port accesses using bits 7:0. With `wide_bus` = 1 it is 64 accesses, where bits 7:0 hold the earlier byte and bits 15:8 the later one.
- R5: The block count decrements by exactly one per block, and only after the last byte of that block has reached the destination side (the host for direction 1, the output stream for direction 0).
- R6: When direction is 0, bit1 reads 0 while the host writes a block. After the host has written all 128 bytes, bit1 reads 1 and the bytes leave on `sout_data` in write order. A byte that is offered and not taken stays on `sout_data` with `sout_valid` held.
- R7: Status bit5 (last byte sent) rises only in the cycle after the output stream takes the final byte of the final block of a direction-0 transfer.
- R8: At normal completion the engine returns to idle with status bit3 = 1 and bit4 (end of transfer) = 1.
- R9: `core_irq` high during a transfer aborts it on the next edge. Bit2 then reads 1, the remaining block count is kept, bit4 stays 0, and both stream handshakes drop. `core_irq` while idle has no effect on the status register.
- R10: Data-port accesses are ignored when the buffer belongs to the stream side. A data-port read then returns 0 and the byte order is not disturbed. A direction write during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_bus | input | 1 | 1 = word accesses on the data port, 0 = byte accesses |
| host_addr | input | ADDR_W | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the addressed register |
| sin_valid | input | 1 | Input stream byte valid (SCSI to host) |
| sin_ready | output | 1 | Engine accepts an input stream byte |
| sin_data | input | 8 | Input stream byte |
| sout_valid | output | 1 | Output stream byte valid (host to SCSI) |
| sout_ready | input | 1 | Output stream accepts the byte |
| sout_data | output | 8 | Output stream byte |
| core_irq | input | 1 | Interrupt from the SCSI core |

## Verification
The assertions take it that `wide_bus` changes only while the engine is idle, that each host access is a single strobe with read and write never high together, and that `core_irq` arrives as a pulse rather than being held through a new start. The bench switches the strap only between transfers and drives every access through one task that raises a single strobe for one cycle. Stream handshakes are stalled at random from a fixed seed, and interrupts are pulsed at chosen points mid-block.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int BLK_BYTES = 128;
  localparam int IDX_W     = $clog2(BLK_BYTES);

  localparam int OFS_DATA  = 8;
  localparam int OFS_CSR   = 9;
  localparam int OFS_CNT   = 10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEV  = 2'd1,
    PH_HOST = 2'd2
  } phase_t;
endpackage

// File: rtl/pdma_buf.sv
module pdma_buf
  import pdma_pkg::*;
(
  input  logic             clk,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [IDX_W-1:0] addr,
  input  logic [15:0]      wdata,
  output logic [7:0]       rd_lo,
  output logic [7:0]       rd_hi
);
  logic [7:0]       mem [BLK_BYTES];
  logic [IDX_W-1:0] addr_hi;

  assign addr_hi = addr + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (we_lo) mem[addr]    <= wdata[7:0];
    if (we_hi) mem[addr_hi] <= wdata[15:8];
  end

  assign rd_lo = mem[addr];
  assign rd_hi = mem[addr_hi];
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             csr_wr,
  input  logic             csr_dir,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             core_irq,
  input  logic             dev_fire,
  input  logic             host_fire,
  output phase_t           phase_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             dir_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic             end_q,
  output logic             last_q
);
  phase_t           phase_n;
  logic [IDX_W-1:0] idx_n;
  logic [CNT_W-1:0] cnt_n;
  logic             dir_n, irq_n, end_n, last_n;
  logic             move, step2, blk_done, final_blk;
  logic [IDX_W:0]   idx_sum;

  assign move      = (phase_q == PH_DEV) ? dev_fire :
                     (phase_q == PH_HOST) ? host_fire : 1'b0;
  assign step2     = (phase_q == PH_HOST) && wide;
  assign idx_sum   = {1'b0, idx_q} + (step2 ? (IDX_W+1)'(2) : (IDX_W+1)'(1));
  assign blk_done  = idx_sum[IDX_W];
  assign final_blk = (cnt_q == CNT_W'(1));

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    dir_n   = dir_q;
    irq_n   = irq_q;
    end_n   = end_q;
    last_n  = last_q;
    if (phase_q == PH_IDLE) begin
      if (csr_wr) dir_n = csr_dir;
      if (cnt_wr) begin
        cnt_n = cnt_val;
        if (cnt_val != '0) begin
          idx_n   = '0;
          irq_n   = 1'b0;
          end_n   = 1'b0;
          last_n  = 1'b0;
          phase_n = (csr_wr ? csr_dir : dir_q) ? PH_DEV : PH_HOST;
        end
      end
    end else if (core_irq) begin
      phase_n = PH_IDLE;
      irq_n   = 1'b1;
    end else if (move) begin
      idx_n = idx_sum[IDX_W-1:0];
      if (blk_done) begin
        // destination side: host when reading, stream when writing
        if ((phase_q == PH_HOST) == dir_q) begin
          cnt_n = cnt_q - CNT_W'(1);
          if (final_blk) begin
            phase_n = PH_IDLE;
            end_n   = 1'b1;
            last_n  = !dir_q;
          end else begin
            phase_n = (phase_q == PH_HOST) ? PH_DEV : PH_HOST;
          end
        end else begin
          phase_n = (phase_q == PH_HOST) ? PH_DEV : PH_HOST;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      irq_q   <= 1'b0;
      end_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      dir_q   <= dir_n;
      irq_q   <= irq_n;
      end_q   <= end_n;
      last_q  <= last_n;
    end
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_bus,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic [7:0]        sin_data,
  output logic              sout_valid,
  input  logic              sout_ready,
  output logic [7:0]        sout_data,
  input  logic              core_irq
);
  logic [1:0]       rs_q;
  logic             rst_n_i;
  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q, irq_q, end_q, last_q;
  logic             sel_data, sel_csr, sel_cnt;
  logic             host_fire, dev_fire;
  logic             we_lo, we_hi;
  logic [15:0]      buf_wdata;
  logic [7:0]       rd_lo, rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  assign sel_data = (host_addr == ADDR_W'(OFS_DATA));
  assign sel_csr  = (host_addr == ADDR_W'(OFS_CSR));
  assign sel_cnt  = (host_addr == ADDR_W'(OFS_CNT));

  assign host_fire = (phase_q == PH_HOST) && sel_data &&
                     (dir_q ? host_rd : host_wr);
  assign sin_ready  = (phase_q == PH_DEV) && dir_q;
  assign sout_valid = (phase_q == PH_DEV) && !dir_q;
  assign dev_fire   = dir_q ? (sin_valid && sin_ready) : (sout_valid && sout_ready);

  assign we_lo     = dir_q ? (dev_fire && (phase_q == PH_DEV)) : host_fire;
  assign we_hi     = !dir_q && host_fire && wide_bus;
  assign buf_wdata = dir_q ? {8'h00, sin_data} : host_wdata;
  assign sout_data = rd_lo;

  pdma_buf u_buf (
    .clk   (clk),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .addr  (idx_q),
    .wdata (buf_wdata),
    .rd_lo (rd_lo),
    .rd_hi (rd_hi)
  );

  pdma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wide      (wide_bus),
    .csr_wr    (host_wr && sel_csr),
    .csr_dir   (host_wdata[0]),
    .cnt_wr    (host_wr && sel_cnt),
    .cnt_val   (host_wdata[CNT_W-1:0]),
    .core_irq  (core_irq),
    .dev_fire  (dev_fire),
    .host_fire (host_fire),
    .phase_q   (phase_q),
    .idx_q     (idx_q),
    .dir_q     (dir_q),
    .cnt_q     (cnt_q),
    .irq_q     (irq_q),
    .end_q     (end_q),
    .last_q    (last_q)
  );

  always_comb begin
    host_rdata = 16'h0000;
    if (sel_data) begin
      if ((phase_q == PH_HOST) && dir_q)
        host_rdata = wide_bus ? {rd_hi, rd_lo} : {8'h00, rd_lo};
    end else if (sel_csr) begin
      host_rdata = {10'd0, last_q, end_q, (phase_q == PH_IDLE), irq_q,
                    (phase_q != PH_HOST), dir_q};
    end else if (sel_cnt) begin
      host_rdata = 16'(cnt_q);
    end
  end
endmodule

// File: rtl/pdma_engine_chk.sv
module pdma_engine_chk
  import pdma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input phase_t           phase_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sin_ready,
  input logic             sout_valid,
  input logic             sout_ready,
  input logic [7:0]       sout_data,
  input logic             core_irq,
  input logic             irq_q,
  input logic             end_q,
  input logic             last_q
);
  assert_stream_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sin_ready && sout_valid));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !sout_ready && !core_irq) |=> (sout_valid && $stable(sout_data)));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && (phase_q != PH_IDLE)) |=> ((phase_q == PH_IDLE) && irq_q));

  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (phase_q == PH_IDLE));

  assert_last_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_q) |-> $past(sout_valid && sout_ready));
endmodule

bind pdma_engine pdma_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_i),
  .phase_q    (phase_q),
  .cnt_q      (cnt_q),
  .sin_ready  (sin_ready),
  .sout_valid (sout_valid),
  .sout_ready (sout_ready),
  .sout_data  (sout_data),
  .core_irq   (core_irq),
  .irq_q      (irq_q),
  .end_q      (end_q),
  .last_q     (last_q)
);

// File: tb/tb_pdma_engine.sv
`timescale 1ns/1ps
module tb_pdma_engine;
  localparam int A_DATA = 8, A_CSR = 9, A_CNT = 10;
  localparam int B_DIR = 0, B_BUSY = 1, B_IRQ = 2, B_AVAIL = 3, B_END = 4, B_LAST = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_bus;
  logic [3:0]  host_addr;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic        sin_valid, sin_ready;
  logic [7:0]  sin_data;
  logic        sout_valid, sout_ready;
  logic [7:0]  sout_data;
  logic        core_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_blk [128];

  always #2.5 clk = ~clk;

  pdma_engine dut (
    .clk(clk), .rst_n(rst_n), .wide_bus(wide_bus),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_data(sin_data),
    .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_data(sout_data),
    .core_irq(core_irq)
  );

  function automatic logic [15:0] exp_word(input int k, input bit wide);
    return wide ? {ref_blk[2*k+1], ref_blk[2*k]} : {8'h00, ref_blk[k]};
  endfunction

  function automatic logic [15:0] exp_done_csr(input bit dir);
    return 16'((1 << B_BUSY) | (1 << B_AVAIL) | (1 << B_END) |
               (dir ? (1 << B_DIR) : (1 << B_LAST)));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic acc(input bit w, input int a, input logic [15:0] d,
                     output logic [15:0] q);
    @(negedge clk);
    host_addr = 4'(a); host_wr = w; host_rd = !w; host_wdata = d;
    #1 q = host_rdata;
    @(posedge clk);
    #1 host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    logic [15:0] q;
    acc(1'b1, a, d, q);
  endtask

  task automatic rd(input int a, output logic [15:0] q);
    acc(1'b0, a, 16'h0, q);
  endtask

  task automatic fill_ref();
    for (int i = 0; i < 128; i++) ref_blk[i] = 8'($urandom);
  endtask

  task automatic feed(input int from, input int upto);
    int i;
    bit took;
    i = from;
    while (i < upto) begin
      @(negedge clk);
      sin_valid = ($urandom % 4) != 0;
      sin_data  = ref_blk[i];
      #1 took = sin_valid && sin_ready;
      @(posedge clk);
      if (took) i++;
    end
    @(negedge clk);
    sin_valid = 1'b0;
  endtask

  task automatic drain(input bit final_blk);
    int j;
    bit took;
    j = 0;
    while (j < 128) begin
      @(negedge clk);
      sout_ready = ($urandom % 3) != 0;
      host_addr  = 4'(A_CSR);
      #1 took = sout_valid && sout_ready;
      if (took) begin
        chk(sout_data == ref_blk[j], "R6 output byte order", sout_data, ref_blk[j]);
        if (j == 127)
          chk(host_rdata[B_LAST] == 1'b0, "R7 last-sent before final take",
              host_rdata[B_LAST], 0);
      end
      @(posedge clk);
      if (took) j++;
    end
    @(negedge clk);
    sout_ready = 1'b0;
    #1 chk(host_rdata[B_LAST] == final_blk, "R7 last-sent after block",
           host_rdata[B_LAST], final_blk);
  endtask

  task automatic host_read_block(input bit wide, input int cnt_before);
    logic [15:0] q;
    int n;
    n = wide ? 64 : 128;
    for (int k = 0; k < n; k++) begin
      if (k == n - 1) begin
        rd(A_CNT, q);
        chk(q == 16'(cnt_before), "R5 count held before last host access", q, cnt_before);
      end
      rd(A_DATA, q);
      chk(q == exp_word(k, wide), wide ? "R4 word read" : "R3 R4 byte read",
          q, exp_word(k, wide));
    end
  endtask

  task automatic host_write_block(input bit wide);
    int n;
    n = wide ? 64 : 128;
    for (int k = 0; k < n; k++) wr(A_DATA, exp_word(k, wide));
  endtask

  task automatic run_xfer(input bit dir, input bit wide, input int nblk);
    logic [15:0] q;
    wide_bus = wide;
    wr(A_CSR, 16'(dir));
    wr(A_CNT, 16'(nblk));
    rd(A_CSR, q);
    chk(q[B_BUSY] == dir, "R3 R6 buffer-not-ready at start", q[B_BUSY], dir);
    chk(q[B_AVAIL] == 1'b0 && q[B_END] == 1'b0, "R2 start clears status", q, 0);
    for (int b = 0; b < nblk; b++) begin
      fill_ref();
      if (dir) begin
        feed(0, 128);
        rd(A_CSR, q);
        chk(q[B_BUSY] == 1'b0, "R3 buffer ready after fill", q[B_BUSY], 0);
        host_read_block(wide, nblk - b);
      end else begin
        host_write_block(wide);
        rd(A_CSR, q);
        chk(q[B_BUSY] == 1'b1, "R6 buffer busy after host block", q[B_BUSY], 1);
        rd(A_CNT, q);
        chk(q == 16'(nblk - b), "R5 count held until stream drains", q, nblk - b);
        drain(b == nblk - 1);
      end
      rd(A_CNT, q);
      chk(q == 16'(nblk - b - 1), "R5 R2 count after block", q, nblk - b - 1);
    end
    rd(A_CSR, q);
    chk(q == exp_done_csr(dir), "R8 completion status", q, exp_done_csr(dir));
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int seed;
    seed = $urandom(32'd7341);
    rst_n = 1'b0; wide_bus = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; sin_valid = 1'b0; sin_data = '0; sout_ready = 1'b0; core_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CSR, q);
    chk(q == 16'h000A, "R1 reset status", q, 16'h000A);
    rd(A_CNT, q);
    chk(q == 16'h0000, "R1 reset count", q, 0);
    chk(!sin_ready && !sout_valid, "R1 stream idle", {sin_ready, sout_valid}, 0);

    // R2 zero count starts nothing
    wr(A_CSR, 16'h0001);
    wr(A_CNT, 16'h0000);
    rd(A_CSR, q);
    chk(q[B_AVAIL] == 1'b1 && !sin_ready, "R2 zero count no start", q, 16'h000B);

    // R10 ignored data-port access and direction write during fill; R2 count write ignored
    wide_bus = 1'b0;
    wr(A_CNT, 16'd1);
    fill_ref();
    feed(0, 40);
    rd(A_DATA, q);
    chk(q == 16'h0000, "R10 data read during fill", q, 0);
    wr(A_CSR, 16'h0000);
    rd(A_CSR, q);
    chk(q[B_DIR] == 1'b1, "R10 direction write ignored", q[B_DIR], 1);
    wr(A_CNT, 16'd5);
    rd(A_CNT, q);
    chk(q == 16'd1, "R2 count write during transfer ignored", q, 1);
    feed(40, 128);
    host_read_block(1'b0, 1);
    rd(A_CSR, q);
    chk(q == exp_done_csr(1'b1), "R8 completion after directed read", q, exp_done_csr(1'b1));

    // R9 interrupt while idle has no effect
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
    rd(A_CSR, q);
    chk(q == exp_done_csr(1'b1), "R9 idle interrupt ignored", q, exp_done_csr(1'b1));

    // R9 abort mid-block
    wr(A_CNT, 16'd2);
    fill_ref();
    feed(0, 50);
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
    #1 chk(!sin_ready, "R9 stream stops on abort", sin_ready, 0);
    rd(A_CSR, q);
    chk(q[B_IRQ] && q[B_AVAIL] && !q[B_END], "R9 abort status", q, 16'h000F);
    rd(A_CNT, q);
    chk(q == 16'd2, "R9 count kept on abort", q, 2);

    // R9 abort while host writes, output stream must not start
    wide_bus = 1'b1;
    wr(A_CSR, 16'h0000);
    wr(A_CNT, 16'd1);
    rd(A_CSR, q);
    chk(q[B_IRQ] == 1'b0, "R2 start clears interrupt bit", q[B_IRQ], 0);
    for (int k = 0; k < 10; k++) wr(A_DATA, 16'(k));
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
    #1 chk(!sout_valid, "R9 no output after abort", sout_valid, 0);

    // directed corner: wide read, wide write, multi-block
    run_xfer(1'b1, 1'b1, 2);
    run_xfer(1'b0, 1'b0, 2);
    run_xfer(1'b0, 1'b1, 1);

    // random mix
    for (int t = 0; t < 6; t++)
      run_xfer(1'($urandom), 1'($urandom), 1 + ($urandom % 3));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule